// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Sequencer

This block takes one transmit frame descriptor out of a descriptor ring in word-addressed memory and turns it into a series of buffer read requests. The buffers named by those requests, joined in order, make up one outgoing frame. A caller gives a ring base and a descriptor slot index. The block reads the descriptor's header word to learn how many buffer entries are active. It then walks the packed entry table, puts each entry's split address and length back together, and presents one request at a time on a valid/ready port.

Entries are six bytes long, so every second entry straddles two 32-bit memory words. The block keeps the previous word so that it can rebuild those entries without reading the word again. While it gathers, it checks each buffer against the per-buffer size limit and adds each length to a running frame total, which it checks against the frame size limit. A malformed descriptor stops the walk and sets a sticky error flag. A descriptor that completes gives a one-cycle done pulse.

Top module: `sg_desc_seq`

## Requirements
- R1: The descriptor for slot `start_index` starts at byte address `ring_base*256 + start_index*128`. Its word `w` is read at word address `ring_base*64 + start_index*32 + w`. The ring base does not have to be 32 KB aligned, so this is a true sum.
- R2: The active entry count is bits [4:0] of descriptor byte 3, which is word 0 bits [28:24]. Bytes 0 to 2 and byte 3 bits [7:5] have no effect on the requests.
- R3: Entry k starts at byte `4 + 6*k`, stored little-endian. Its first 4 bytes are address bits [31:0]. The 16-bit field that follows carries address bits [35:32] in its bits [3:0] and the buffer length in its bits [15:4]. An entry that straddles two words is rebuilt correctly.
- R4: The block presents one request per active entry, in entry order, on `req_valid`/`req_ready`. While a request waits for `req_ready`, its address and length stay unchanged. `req_last` is high on the request for the final entry.
- R5: A count of 0 or a count above 20 sets the error flag and produces no request.
- R6: A buffer length above 4092 sets the error flag and ends the walk before that entry is presented. Earlier entries are still presented.
- R7: If the running frame total would go above 8192 bytes, the error flag is set and that entry is not presented. A total of exactly 8192 is accepted.
- R8: The error flag stays high until `err_clr` is pulsed, which clears it.
- R9: `done` is high for exactly one cycle, in the cycle after the final request is accepted. A descriptor that ends in an error gives no `done`.
- R10: `start_ready` is high only while the block is idle. A `start_valid` seen while the block is busy is ignored and starts no second walk.
- R11: After reset the block is idle. `start_ready` is 1, and `req_valid`, `done`, `err_flag` and `mem_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Request to process one descriptor |
| start_ready | output | 1 | High while idle; a start is taken when both are high |
| start_index | input | 8 | Descriptor slot within the ring |
| ring_base | input | 28 | Ring base address bits [35:8] |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_addr | output | 34 | Word address, which is byte address bits [35:2] |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| req_valid | output | 1 | Buffer request valid |
| req_ready | input | 1 | Buffer request accepted when high with valid |
| req_addr | output | 36 | Buffer start byte address |
| req_len | output | 12 | Buffer length in bytes |
| req_last | output | 1 | Request belongs to the final entry |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Sticky malformed-descriptor flag |
| err_clr | input | 1 | Write-one-to-clear pulse for `err_flag` |

## Verification
The hardest cases to reach are the limit failures in the middle of a descriptor. A frame that fails on its third buffer must first present two good buffers, and the error must then cut off the walk without a `done` pulse. The bench builds such descriptors byte by byte in its memory model: one entry of length 4093 placed after good ones, and a set of lengths that sums to exactly 8192 next to one that sums to 8193. Some of the bad entries sit in odd slots, so the rejection also goes through the word-straddling path. Backpressure patterns on `req_ready` stall requests while the walk is in flight. A second start pulse is driven during a busy walk to show that it is dropped.

// File: rtl/sg_desc_pkg.sv
// Package: shared constants and state types for the descriptor sequencer.
// Assumes 32-bit little-endian descriptor memory words.
package sg_desc_pkg;
    localparam int ADDR_W      = 36;    // buffer byte address width
    localparam int LEN_W       = 12;    // buffer length field width
    localparam int CNT_W       = 5;     // entry count field width
    localparam int IDX_W       = 8;     // descriptor slot index width
    localparam int BASE_W      = 28;    // ring base holds address [35:8]
    localparam int MAX_ENTRIES = 20;    // most entries in a descriptor
    localparam int MAX_BUF     = 4092;  // largest single buffer
    localparam int MAX_FRAME   = 8192;  // largest gathered frame
    localparam int DESC_WORDS  = 32;    // 128-byte descriptor
    localparam int WIDX_W      = $clog2(DESC_WORDS);
    localparam int WADDR_W     = ADDR_W - 2;
    localparam int TOT_W       = $clog2(MAX_FRAME + (1 << LEN_W));

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LAND,
        ST_ISSUE
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_LO,
        PH_HI
    } fetch_phase_t;
endpackage

// File: rtl/sg_desc_addr.sv
// Module: forms the memory word address of one descriptor word.
// Assumes the ring base is 256-byte aligned but not ring-size aligned,
// so slot and word offsets are added rather than concatenated.
module sg_desc_addr
    import sg_desc_pkg::*;
(
    input  logic [BASE_W-1:0]  base,
    input  logic [IDX_W-1:0]   index,
    input  logic [WIDX_W-1:0]  widx,
    output logic [WADDR_W-1:0] waddr
);
    localparam int SLOT_SH = $clog2(DESC_WORDS);

    // Sum of ring base, slot offset and word offset, all in words.
    always_comb begin
        waddr = {base, 6'b0}
              + WADDR_W'({index, {SLOT_SH{1'b0}}})
              + WADDR_W'(widx);
    end
endmodule

// File: rtl/sg_entry_unpack.sv
// Module: rebuilds one 6-byte buffer entry from two memory words.
// Even entries: held = low address word, rdata[15:0] = high/length field.
// Odd entries: held[31:16] and rdata[15:0] = low address, rdata[31:16] = field.
module sg_entry_unpack
    import sg_desc_pkg::*;
(
    input  logic [31:0]       held,
    input  logic [31:0]       rdata,
    input  logic              odd,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len
);
    logic [31:0] lo_word;
    logic [15:0] hl_field;

    // Select the halves that belong to this entry's parity.
    always_comb begin
        lo_word  = odd ? {rdata[15:0], held[31:16]} : held;
        hl_field = odd ? rdata[31:16] : rdata[15:0];
        buf_addr = {hl_field[3:0], lo_word};
        buf_len  = hl_field[15:4];
    end
endmodule

// File: rtl/sg_len_guard.sv
// Module: checks one buffer length against the per-buffer and frame limits.
// Assumes the running total passed in never exceeds the frame limit.
module sg_len_guard
    import sg_desc_pkg::*;
(
    input  logic [LEN_W-1:0] buf_len,
    input  logic [TOT_W-1:0] total,
    output logic [TOT_W-1:0] new_total,
    output logic             buf_over,
    output logic             frame_over
);
    // Limit comparisons on the candidate entry.
    always_comb begin
        new_total  = total + TOT_W'(buf_len);
        buf_over   = buf_len > LEN_W'(MAX_BUF);
        frame_over = new_total > TOT_W'(MAX_FRAME);
    end
endmodule

// File: rtl/sg_desc_seq.sv
// Module: top-level descriptor walker. Reads the header word, then streams
// entry words (one read per word, 1-cycle read latency), checks limits and
// presents each buffer on a valid/ready port. Assumes mem_rdata is valid in
// the cycle after mem_rd_en and that start is sampled only while idle.
module sg_desc_seq
    import sg_desc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    output logic               start_ready,
    input  logic [IDX_W-1:0]   start_index,
    input  logic [BASE_W-1:0]  ring_base,
    output logic               mem_rd_en,
    output logic [WADDR_W-1:0] mem_addr,
    input  logic [31:0]        mem_rdata,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_len,
    output logic               req_last,
    output logic               done,
    output logic               err_flag,
    input  logic               err_clr
);
    seq_state_t        state;
    fetch_phase_t      phase;
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WIDX_W-1:0] widx;
    logic [CNT_W-1:0]  ent_k;
    logic [CNT_W-1:0]  ent_cnt;
    logic [31:0]       held;
    logic [TOT_W-1:0]  total;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              last_q;
    logic              done_q;
    logic              err_q;

    logic [ADDR_W-1:0] ent_addr;
    logic [LEN_W-1:0]  ent_len;
    logic [TOT_W-1:0]  sum_total;
    logic              buf_over;
    logic              frame_over;
    logic [CNT_W-1:0]  hdr_cnt;
    logic              hdr_bad;
    logic [CNT_W-1:0]  k_next;

    sg_desc_addr u_addr (
        .base  (base_q),
        .index (idx_q),
        .widx  (widx),
        .waddr (mem_addr)
    );

    sg_entry_unpack u_unpack (
        .held     (held),
        .rdata    (mem_rdata),
        .odd      (ent_k[0]),
        .buf_addr (ent_addr),
        .buf_len  (ent_len)
    );

    sg_len_guard u_guard (
        .buf_len    (ent_len),
        .total      (total),
        .new_total  (sum_total),
        .buf_over   (buf_over),
        .frame_over (frame_over)
    );

    // Header decode: count field and its range check.
    always_comb begin
        hdr_cnt = mem_rdata[24 +: CNT_W];
        hdr_bad = (hdr_cnt == '0) || (hdr_cnt > CNT_W'(MAX_ENTRIES));
        k_next  = ent_k + 1'b1;
    end

    // Output drives from registered state.
    always_comb begin
        start_ready = (state == ST_IDLE);
        mem_rd_en   = (state == ST_FETCH);
        req_valid   = (state == ST_ISSUE);
        req_addr    = addr_q;
        req_len     = len_q;
        req_last    = last_q;
        done        = done_q;
        err_flag    = err_q;
    end

    // Sequencer: fetch, land, issue, with the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_HDR;
            base_q  <= '0;
            idx_q   <= '0;
            widx    <= '0;
            ent_k   <= '0;
            ent_cnt <= '0;
            held    <= '0;
            total   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (err_clr) begin
                err_q <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (start_valid) begin
                        base_q <= ring_base;
                        idx_q  <= start_index;
                        widx   <= '0;
                        ent_k  <= '0;
                        total  <= '0;
                        phase  <= PH_HDR;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    state <= ST_LAND;
                end
                ST_LAND: begin
                    case (phase)
                        PH_HDR: begin
                            if (hdr_bad) begin
                                err_q <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                ent_cnt <= hdr_cnt;
                                widx    <= widx + 1'b1;
                                phase   <= PH_LO;
                                state   <= ST_FETCH;
                            end
                        end
                        PH_LO: begin
                            held  <= mem_rdata;
                            widx  <= widx + 1'b1;
                            phase <= PH_HI;
                            state <= ST_FETCH;
                        end
                        default: begin
                            if (buf_over || frame_over) begin
                                err_q <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                held   <= mem_rdata;
                                widx   <= widx + 1'b1;
                                total  <= sum_total;
                                addr_q <= ent_addr;
                                len_q  <= ent_len;
                                last_q <= (k_next == ent_cnt);
                                state  <= ST_ISSUE;
                            end
                        end
                    endcase
                end
                default: begin
                    if (req_ready) begin
                        ent_k <= k_next;
                        if (last_q) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            phase <= k_next[0] ? PH_HI : PH_LO;
                            state <= ST_FETCH;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sg_desc_seq_chk.sv
// Module: protocol checker for sg_desc_seq, attached with bind.
// Tracks the accepted byte total per descriptor in its own counter.
module sg_desc_seq_chk
    import sg_desc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic              start_ready,
    input logic              mem_rd_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic              req_last,
    input logic              done,
    input logic              err_flag,
    input logic              err_clr
);
    logic [TOT_W:0] acc_sum;

    // Running total of accepted lengths since the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sum <= '0;
        end else if (start_valid && start_ready) begin
            acc_sum <= '0;
        end else if (req_valid && req_ready) begin
            acc_sum <= acc_sum + (TOT_W + 1)'(req_len);
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_len) && $stable(req_last));

    assert_buf_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len <= LEN_W'(MAX_BUF));

    assert_frame_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> acc_sum + (TOT_W + 1)'(req_len) <= (TOT_W + 1)'(MAX_FRAME));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag);

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && req_ready && req_last));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> !req_valid && !mem_rd_en);
endmodule

bind sg_desc_seq sg_desc_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .mem_rd_en   (mem_rd_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_last    (req_last),
    .done        (done),
    .err_flag    (err_flag),
    .err_clr     (err_clr)
);

// File: tb/sg_desc_seq_tb_top.sv
`timescale 1ns/100ps
// Bench: byte-built descriptor memory, scoreboard queue filled by the driver
// from the requirements, monitor pops on each accepted request.
module sg_desc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [7:0]  start_index = '0;
    logic [27:0] ring_base = '0;
    logic        mem_rd_en;
    logic [33:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [35:0] req_addr;
    logic [11:0] req_len;
    logic        req_last;
    logic        done;
    logic        err_flag;
    logic        err_clr = 1'b0;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int cycles = 0;
    int ready_mode = 0;
    int rdy_ctr = 0;
    logic [47:0] exp_q[$];
    logic        exp_last_q[$];
    logic [31:0] mem [0:4095];

    always #2.5 clk = ~clk;

    sg_desc_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_index(start_index), .ring_base(ring_base),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_last(req_last),
        .done(done), .err_flag(err_flag), .err_clr(err_clr)
    );

    // Memory model with one cycle of read latency.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];

    // Backpressure pattern, driven just after the edge.
    always @(posedge clk) begin
        #1;
        rdy_ctr = rdy_ctr + 1;
        case (ready_mode)
            0: req_ready = 1'b1;
            1: req_ready = rdy_ctr[0];
            default: req_ready = (rdy_ctr % 5) >= 3;
        endcase
    end

    task automatic check(input bit ok, input string req, input string msg,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, msg, act, expv);
        end
    endtask

    // Monitor: compare every accepted request against the scoreboard.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && done) done_cnt++;
        if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R4", "unexpected request", {req_addr, req_len}, 0);
            end else begin
                logic [47:0] e;
                logic        el;
                e  = exp_q.pop_front();
                el = exp_last_q.pop_front();
                check({req_addr, req_len} == e, "R3", "request addr/len",
                      {req_addr, req_len}, e);
                check(req_last == el, "R4", "last marker", req_last, el);
            end
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int dbase(input logic [27:0] b, input int idx);
        return int'(b) * 256 + idx * 128;
    endfunction

    task automatic wr_byte(input int ba, input logic [7:0] v);
        mem[ba / 4][8 * (ba % 4) +: 8] = v;
    endtask

    function automatic logic [7:0] rd_byte(input int ba);
        return mem[ba / 4][8 * (ba % 4) +: 8];
    endfunction

    // Build a descriptor: header byte, junk in reserved bytes, then entries.
    task automatic put_hdr(input logic [27:0] b, input int idx, input logic [7:0] hb);
        int d;
        d = dbase(b, idx);
        for (int i = 0; i < 128; i++) wr_byte(d + i, 8'h00);
        wr_byte(d + 0, 8'hA5);
        wr_byte(d + 1, 8'h3C);
        wr_byte(d + 2, 8'hFF);
        wr_byte(d + 3, hb);
    endtask

    task automatic put_ent(input logic [27:0] b, input int idx, input int k,
                           input logic [35:0] a, input logic [11:0] l);
        int o;
        logic [15:0] hl;
        o  = dbase(b, idx) + 4 + 6 * k;
        hl = {l, a[35:32]};
        for (int i = 0; i < 4; i++) wr_byte(o + i, a[8 * i +: 8]);
        wr_byte(o + 4, hl[7:0]);
        wr_byte(o + 5, hl[15:8]);
    endtask

    // Reference walk from R2, R3, R5, R6, R7; returns expected error.
    function automatic bit expect_walk(input logic [27:0] b, input int idx);
        int d, cnt, tot;
        d   = dbase(b, idx);
        cnt = int'(rd_byte(d + 3) & 8'h1F);
        tot = 0;
        if (cnt == 0 || cnt > 20) return 1'b1;
        for (int k = 0; k < cnt; k++) begin
            int o, l;
            logic [35:0] a;
            logic [15:0] hl;
            o  = d + 4 + 6 * k;
            hl = {rd_byte(o + 5), rd_byte(o + 4)};
            a  = {hl[3:0], rd_byte(o + 3), rd_byte(o + 2), rd_byte(o + 1), rd_byte(o)};
            l  = int'(hl[15:4]);
            if (l > 4092 || tot + l > 8192) return 1'b1;
            tot += l;
            exp_q.push_back({a, hl[15:4]});
            exp_last_q.push_back(k == cnt - 1);
        end
        return 1'b0;
    endfunction

    task automatic run_desc(input logic [27:0] b, input int idx, input int rmode,
                            input bit poke_busy, input string req);
        bit exp_err;
        int d0, waitc;
        ready_mode = rmode;
        exp_err = expect_walk(b, idx);
        d0 = done_cnt;
        @(posedge clk); #1;
        ring_base = b; start_index = 8'(idx); start_valid = 1'b1;
        @(posedge clk); #1;
        start_valid = 1'b0;
        if (poke_busy) begin
            repeat (2) @(posedge clk);
            #1;
            start_index = 8'(idx + 1); start_valid = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check(start_ready == 1'b0, "R10", "ready while busy", start_ready, 0);
            end
            @(posedge clk); #1;
            start_valid = 1'b0;
        end
        waitc = 0;
        @(negedge clk);
        while (!start_ready && waitc < 2000) begin
            @(negedge clk);
            waitc++;
        end
        @(negedge clk);
        check(exp_q.size() == 0, req, "missing requests", exp_q.size(), 0);
        exp_q.delete();
        exp_last_q.delete();
        check(err_flag == exp_err, req, "error flag", err_flag, exp_err);
        check(done_cnt - d0 == (exp_err ? 0 : 1), "R9", "done pulses",
              done_cnt - d0, exp_err ? 0 : 1);
        if (err_flag) begin
            @(posedge clk); #1;
            err_clr = 1'b1;
            @(posedge clk); #1;
            err_clr = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(start_ready && !req_valid && !done && !err_flag && !mem_rd_en,
              "R11", "reset state", {start_ready, req_valid, done, err_flag, mem_rd_en},
              5'b10000);

        // R2/R3: single entry, junk in reserved bits of byte 3 and bytes 0-2.
        put_hdr(28'h2, 0, 8'hE1);
        put_ent(28'h2, 0, 0, 36'hA_1234_5678, 12'd100);
        run_desc(28'h2, 0, 0, 0, "R2");

        // R3/R4: three entries across straddled words, alternating backpressure.
        put_hdr(28'h2, 1, 8'h03);
        put_ent(28'h2, 1, 0, 36'h1_0000_0010, 12'd64);
        put_ent(28'h2, 1, 1, 36'hF_DEAD_BEEF, 12'd1500);
        put_ent(28'h2, 1, 2, 36'h7_CAFE_F00D, 12'd9);
        run_desc(28'h2, 1, 1, 0, "R4");

        // R1: base not ring-aligned, slot offset carries into base bits.
        put_hdr(28'h5, 7, 8'h02);
        put_ent(28'h5, 7, 0, 36'h3_0101_0202, 12'd2);
        put_ent(28'h5, 7, 1, 36'h4_0303_0404, 12'd4000);
        run_desc(28'h5, 7, 2, 0, "R1");

        // R4: full 20 entries, uneven backpressure.
        put_hdr(28'h2, 2, 8'd20);
        for (int k = 0; k < 20; k++)
            put_ent(28'h2, 2, k, {4'(k), 32'h1000_0000 + 32'(k * 'h111)}, 12'(300 + k));
        run_desc(28'h2, 2, 2, 0, "R4");

        // R5: zero count and count of 21.
        put_hdr(28'h2, 3, 8'h00);
        run_desc(28'h2, 3, 0, 0, "R5");
        put_hdr(28'h2, 4, 8'd21);
        put_ent(28'h2, 4, 0, 36'h1, 12'd1);
        run_desc(28'h2, 4, 0, 0, "R5");

        // R6: exactly 4092 accepted; 4093 in an odd slot rejected after entry 0.
        put_hdr(28'h2, 5, 8'h01);
        put_ent(28'h2, 5, 0, 36'h2_0000_1000, 12'd4092);
        run_desc(28'h2, 5, 0, 0, "R6");
        put_hdr(28'h2, 6, 8'h03);
        put_ent(28'h2, 6, 0, 36'h2_0000_2000, 12'd10);
        put_ent(28'h2, 6, 1, 36'h2_0000_3000, 12'd4093);
        put_ent(28'h2, 6, 2, 36'h2_0000_4000, 12'd10);
        run_desc(28'h2, 6, 1, 0, "R6");

        // R7: total exactly 8192 accepted, then 8193 rejected on third entry.
        put_hdr(28'h2, 8, 8'h03);
        put_ent(28'h2, 8, 0, 36'h0_1111_0000, 12'd4092);
        put_ent(28'h2, 8, 1, 36'h0_2222_0000, 12'd4092);
        put_ent(28'h2, 8, 2, 36'h0_3333_0000, 12'd8);
        run_desc(28'h2, 8, 0, 0, "R7");
        put_hdr(28'h2, 9, 8'h03);
        put_ent(28'h2, 9, 0, 36'h0_1111_0000, 12'd4092);
        put_ent(28'h2, 9, 1, 36'h0_2222_0000, 12'd4092);
        put_ent(28'h2, 9, 2, 36'h0_3333_0000, 12'd9);
        run_desc(28'h2, 9, 2, 0, "R7");

        // R8: flag stays set with no clear, then clears on a pulse.
        ready_mode = 0;
        put_hdr(28'h2, 10, 8'h00);
        @(posedge clk); #1;
        ring_base = 28'h2; start_index = 8'd10; start_valid = 1'b1;
        @(posedge clk); #1;
        start_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(err_flag == 1'b1, "R8", "flag held without clear", err_flag, 1);
        @(posedge clk); #1;
        err_clr = 1'b1;
        @(posedge clk); #1;
        err_clr = 1'b0;
        @(negedge clk);
        check(err_flag == 1'b0, "R8", "flag after clear", err_flag, 0);

        // R10: a second start during a busy walk is dropped.
        put_hdr(28'h2, 11, 8'h04);
        for (int k = 0; k < 4; k++)
            put_ent(28'h2, 11, k, 36'h5_0000_0000 + 36'(k * 'h40), 12'(20 + k));
        put_hdr(28'h2, 12, 8'h01);
        put_ent(28'h2, 12, 0, 36'h9_9999_9999, 12'd7);
        run_desc(28'h2, 11, 1, 1, "R10");
        repeat (10) @(negedge clk);
        check(start_ready == 1'b1 && !req_valid, "R10", "no second walk started",
              {start_ready, req_valid}, 2'b10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule